// File: doc/BRIEF.md
# Exception Entry Vector and Cause Unit

This unit decides where a processor core goes when it takes an exception, and what it records on the way. Given one request with the kind of event, the resuming program counter, a delay-slot flag, the translation miss flag and a snapshot of the relevant status, cause and base-address fields, it produces the handler address. It also produces every write that the exception makes to architectural state: the exception code, the exception PC, the branch-delay bit, the level bits, the error-return PC, the debug-return PC and the debug cause flags.

General exceptions start from a base that is either the boot base moved up by 0x200 or the programmable exception base with its low 12 bits cleared. An offset is added to that base. The offset picks out TLB refill, vectored interrupts with programmable spacing, cache errors and the common handler. Debug events, non-maskable interrupts and soft resets use their own entry points, which are fixed relative to the boot base. The logic between request and result is combinational. The result is held in one register stage, so a request accepted on one clock edge is answered with a single response pulse after that edge.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset every output is zero. Each cycle with `req_valid` high gives exactly one cycle with `rsp_valid` high, one clock later, and `rsp_valid` is low when there was no request in the previous cycle.
- R2: General kinds are all kind values except 16, 17 and 25 to 29 and 31. For these the exception code equals the kind value: interrupt 0, modify 1, TLB load 2, TLB store 3, address error load 4 and store 5, bus errors 6 and 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, read-inhibit 19, execute-inhibit 20, machine check 24, cache error 30. `code_we` and `exl_set` are asserted only for general kinds.
- R3: The general base is `boot_base + 0x200` when `st_bev` is 1, and `ebase` with bits 11:0 cleared otherwise. The default offset added to it is 0x180.
- R4: A TLB load (2) or TLB store (3) with `tlb_nomatch` 1 and `st_exl` 0 uses offset 0x000. If either of those two conditions is missing, it uses 0x180.
- R5: An interrupt (kind 0) with `ca_iv` 1 uses offset 0x200 when `st_bev` is 1 or `vec_spacing` is 0, and otherwise 0x200 + vector × (`vec_spacing` × 32). With `ca_iv` 0 it uses 0x180.
- R6: The interrupt vector is the index of the highest set bit of `ca_ip & st_im`, or 0 when that is empty. With `eic_mode` 1 it is the raw `ca_ip` value.
- R7: For a general kind with `st_exl` 0, `epc_we` and `bd_we` are 1, `epc_val` is `cur_pc - 4` when `in_delay` is 1 and `cur_pc` otherwise, and `bd_val` equals `in_delay`. With `st_exl` 1, `epc_we` and `bd_we` are 0 and the code is still written.
- R8: A cache error (30) with `st_bev` 0 jumps to `(0xA0000000 | (ebase & 0x1FFFF000)) + 0x100`. With `st_bev` 1 it jumps to `boot_base + 0x300`.
- R9: The debug kinds are single step 25, debug interrupt 26, instruction break 27, software breakpoint 28, data store break 29 and data load break 31. They set `dbg_flags` bits 0, 1, 2, 3, 4 and 5 respectively, with exactly one bit set. They write `depc_val` and jump to `boot_base + 0x480`, with no code, EPC or level write. `depc_val` is `cur_pc` unchanged for single step and the delay-adjusted resume PC for the others.
- R10: NMI (16) and soft reset (17) assert `erl_set`, `bev_set` and `errpc_we`, give `errpc_val` as the delay-adjusted resume PC and jump to `boot_base`, with no code or EPC write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_kind | input | 5 | Exception kind (encoding in R2, R9, R10) |
| cur_pc | input | 32 | PC of the faulting instruction or of the branch before it |
| in_delay | input | 1 | Faulting instruction sits in a delay slot |
| tlb_nomatch | input | 1 | Translation found no matching entry |
| st_exl | input | 1 | Exception level already set |
| st_bev | input | 1 | Boot exception vectors selected |
| st_im | input | 8 | Interrupt mask |
| ca_iv | input | 1 | Interrupts use the dedicated vector |
| ca_ip | input | 8 | Pending interrupt lines |
| vec_spacing | input | 5 | Vector spacing in units of 32 bytes |
| ebase | input | 32 | Programmable exception base |
| eic_mode | input | 1 | External controller supplies the vector |
| boot_base | input | 32 | Boot exception base |
| rsp_valid | output | 1 | Result strobe |
| next_pc | output | 32 | Handler address |
| code_we | output | 1 | Write exception code |
| exc_code | output | 5 | Exception code for cause bits 6:2 |
| epc_we | output | 1 | Write EPC |
| epc_val | output | 32 | EPC value |
| bd_we | output | 1 | Write branch-delay bit |
| bd_val | output | 1 | Branch-delay value |
| exl_set | output | 1 | Set exception level |
| erl_set | output | 1 | Set error level |
| bev_set | output | 1 | Set boot vectors |
| errpc_we | output | 1 | Write error-return PC |
| errpc_val | output | 32 | Error-return PC value |
| depc_we | output | 1 | Write debug-return PC |
| depc_val | output | 32 | Debug-return PC value |
| dbg_flags | output | 6 | Debug cause flags, one-hot |

## Verification
The assertions assume that the status and base inputs stay stable for the one cycle in which `req_valid` is high, because the checker compares each response with the past value of those inputs. The bench drives every input on the falling edge and holds it until the next falling edge, so each request sees a single consistent snapshot. Requests are at least two cycles apart, so a response never overlaps the next request, and the one-response-per-request property can be observed directly.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam int ADDR_W = 32;

  localparam logic [ADDR_W-1:0] OFS_COMMON = 32'h0000_0180;
  localparam logic [ADDR_W-1:0] OFS_REFILL = 32'h0000_0000;
  localparam logic [ADDR_W-1:0] OFS_CACHE  = 32'h0000_0100;
  localparam logic [ADDR_W-1:0] OFS_IRQ    = 32'h0000_0200;
  localparam logic [ADDR_W-1:0] OFS_DEBUG  = 32'h0000_0480;
  localparam logic [ADDR_W-1:0] BOOT_SHIFT = 32'h0000_0200;
  localparam logic [ADDR_W-1:0] KSEG_UNC   = 32'hA000_0000;
  localparam logic [ADDR_W-1:0] CERR_MASK  = 32'h1FFF_F000;
  localparam int DBG_N = 6;

  typedef enum logic [4:0] {
    K_IRQ    = 5'd0,
    K_TLBL   = 5'd2,
    K_TLBS   = 5'd3,
    K_NMI    = 5'd16,
    K_SRST   = 5'd17,
    K_DSTEP  = 5'd25,
    K_DIRQ   = 5'd26,
    K_DIBRK  = 5'd27,
    K_DSWBP  = 5'd28,
    K_DSTORE = 5'd29,
    K_CERR   = 5'd30,
    K_DLOAD  = 5'd31
  } exc_kind_e;

  function automatic logic kind_is_debug(input logic [4:0] k);
    return (k >= 5'd25 && k <= 5'd29) || k == 5'd31;
  endfunction

  function automatic logic kind_is_errent(input logic [4:0] k);
    return k == K_NMI || k == K_SRST;
  endfunction

  function automatic logic [DBG_N-1:0] debug_flag(input logic [4:0] k);
    logic [DBG_N-1:0] f;
    f = '0;
    if (k == K_DLOAD) f[DBG_N-1] = 1'b1;
    else if (kind_is_debug(k)) f[k - 5'd25] = 1'b1;
    return f;
  endfunction

  function automatic logic [ADDR_W-1:0] resume_pc(input logic [ADDR_W-1:0] pc,
                                                  input logic delay);
    return delay ? pc - 32'd4 : pc;
  endfunction

  function automatic logic [ADDR_W-1:0] spaced_offset(input logic [ADDR_W-1:0] vec,
                                                      input logic [ADDR_W-1:0] spc);
    return OFS_IRQ + vec * (spc << 5);
  endfunction

endpackage

// File: rtl/exc_irq_vec.sv
module exc_irq_vec #(
  parameter int IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] ip,
  input  logic [IRQ_W-1:0] im,
  input  logic             eic,
  output logic [31:0]      vec
);
  localparam int IDX_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;

  logic [IRQ_W-1:0] live;
  logic [IRQ_W-1:0] top_hot;
  logic [IDX_W-1:0] top_idx;

  assign live = ip & im;

  genvar g;
  generate
    for (g = 0; g < IRQ_W; g++) begin : g_top
      if (g == IRQ_W - 1) begin : g_msb
        assign top_hot[g] = live[g];
      end else begin : g_low
        assign top_hot[g] = live[g] & ~(|live[IRQ_W-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < IRQ_W; i++) begin
      if (top_hot[i]) top_idx = top_idx | IDX_W'(i);
    end
  end

  assign vec = eic ? 32'(ip) : 32'(top_idx);
endmodule

// File: rtl/exc_target.sv
module exc_target #(
  parameter int SPC_W = 5
) (
  input  logic [4:0]       kind,
  input  logic             nomatch,
  input  logic             exl,
  input  logic             bev,
  input  logic             iv,
  input  logic [SPC_W-1:0] spacing,
  input  logic [31:0]      vec,
  input  logic [31:0]      ebase,
  input  logic [31:0]      boot,
  output logic [31:0]      target,
  output logic             refill_hit,
  output logic             vint_hit
);
  import exc_vec_pkg::*;

  logic [31:0] base;
  logic [31:0] offset;
  logic        is_cerr;

  assign base       = bev ? boot + BOOT_SHIFT : {ebase[31:12], 12'h000};
  assign is_cerr    = kind == K_CERR;
  assign refill_hit = (kind == K_TLBL || kind == K_TLBS) && nomatch && !exl;
  assign vint_hit   = kind == K_IRQ && iv;

  always_comb begin
    if (refill_hit)                          offset = OFS_REFILL;
    else if (is_cerr)                        offset = OFS_CACHE;
    else if (vint_hit && (bev || spacing == '0)) offset = OFS_IRQ;
    else if (vint_hit)                       offset = spaced_offset(vec, 32'(spacing));
    else                                     offset = OFS_COMMON;
  end

  always_comb begin
    if (is_cerr && !bev) target = (KSEG_UNC | (ebase & CERR_MASK)) + offset;
    else                 target = base + offset;
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int IRQ_W = 8,
  parameter int SPC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [4:0]       req_kind,
  input  logic [31:0]      cur_pc,
  input  logic             in_delay,
  input  logic             tlb_nomatch,
  input  logic             st_exl,
  input  logic             st_bev,
  input  logic [IRQ_W-1:0] st_im,
  input  logic             ca_iv,
  input  logic [IRQ_W-1:0] ca_ip,
  input  logic [SPC_W-1:0] vec_spacing,
  input  logic [31:0]      ebase,
  input  logic             eic_mode,
  input  logic [31:0]      boot_base,
  output logic             rsp_valid,
  output logic [31:0]      next_pc,
  output logic             code_we,
  output logic [4:0]       exc_code,
  output logic             epc_we,
  output logic [31:0]      epc_val,
  output logic             bd_we,
  output logic             bd_val,
  output logic             exl_set,
  output logic             erl_set,
  output logic             bev_set,
  output logic             errpc_we,
  output logic [31:0]      errpc_val,
  output logic             depc_we,
  output logic [31:0]      depc_val,
  output logic [5:0]       dbg_flags
);
  import exc_vec_pkg::*;

  logic        is_debug;
  logic        is_errent;
  logic        is_general;
  logic        refill_hit;
  logic        vint_hit;
  logic [31:0] irq_vec;
  logic [31:0] gen_target;
  logic [31:0] resume;
  logic [31:0] tgt_c;
  logic        save_epc;

  assign is_debug   = kind_is_debug(req_kind);
  assign is_errent  = kind_is_errent(req_kind);
  assign is_general = !is_debug && !is_errent;
  assign resume     = resume_pc(cur_pc, in_delay);
  assign save_epc   = is_general && !st_exl;

  exc_irq_vec #(.IRQ_W(IRQ_W)) u_vec (
    .ip  (ca_ip),
    .im  (st_im),
    .eic (eic_mode),
    .vec (irq_vec)
  );

  exc_target #(.SPC_W(SPC_W)) u_tgt (
    .kind       (req_kind),
    .nomatch    (tlb_nomatch),
    .exl        (st_exl),
    .bev        (st_bev),
    .iv         (ca_iv),
    .spacing    (vec_spacing),
    .vec        (irq_vec),
    .ebase      (ebase),
    .boot       (boot_base),
    .target     (gen_target),
    .refill_hit (refill_hit),
    .vint_hit   (vint_hit)
  );

  always_comb begin
    if (is_debug)       tgt_c = boot_base + OFS_DEBUG;
    else if (is_errent) tgt_c = boot_base;
    else                tgt_c = gen_target;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      next_pc   <= '0;
      code_we   <= 1'b0;
      exc_code  <= '0;
      epc_we    <= 1'b0;
      epc_val   <= '0;
      bd_we     <= 1'b0;
      bd_val    <= 1'b0;
      exl_set   <= 1'b0;
      erl_set   <= 1'b0;
      bev_set   <= 1'b0;
      errpc_we  <= 1'b0;
      errpc_val <= '0;
      depc_we   <= 1'b0;
      depc_val  <= '0;
      dbg_flags <= '0;
    end else begin
      rsp_valid <= req_valid;
      next_pc   <= tgt_c;
      code_we   <= req_valid && is_general;
      exc_code  <= is_general ? req_kind : 5'd0;
      epc_we    <= req_valid && save_epc;
      epc_val   <= resume;
      bd_we     <= req_valid && save_epc;
      bd_val    <= in_delay;
      exl_set   <= req_valid && is_general;
      erl_set   <= req_valid && is_errent;
      bev_set   <= req_valid && is_errent;
      errpc_we  <= req_valid && is_errent;
      errpc_val <= resume;
      depc_we   <= req_valid && is_debug;
      depc_val  <= (req_kind == K_DSTEP) ? cur_pc : resume;
      dbg_flags <= req_valid ? debug_flag(req_kind) : '0;
    end
  end
endmodule

// File: rtl/exc_vector_chk.sv
module exc_vector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [4:0]  req_kind,
  input logic        st_exl,
  input logic        st_bev,
  input logic [31:0] ebase,
  input logic [31:0] boot_base,
  input logic        refill_hit,
  input logic        rsp_valid,
  input logic [31:0] next_pc,
  input logic        code_we,
  input logic        epc_we,
  input logic        bd_we,
  input logic        exl_set,
  input logic        errpc_we,
  input logic        erl_set,
  input logic        bev_set,
  input logic        depc_we,
  input logic [5:0]  dbg_flags
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R1
  AST_CODE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    code_we |-> exl_set && rsp_valid); // R2
  AST_REFILL_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && refill_hit && !st_bev) |=> next_pc == {$past(ebase[31:12]), 12'h000}); // R4
  AST_EPC_EXL: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |-> $past(!st_exl) && bd_we && code_we); // R7
  AST_DBG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dbg_flags) && (depc_we == ($countones(dbg_flags) == 1))); // R9
  AST_DBG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    depc_we |-> !epc_we && !code_we && next_pc == $past(boot_base) + 32'h480); // R9
  AST_ERR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    errpc_we |-> erl_set && bev_set && !code_we && next_pc == $past(boot_base)); // R10
  AST_ERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 5'd16 || req_kind == 5'd17)) |=> errpc_we); // R10
endmodule

bind exc_vector_unit exc_vector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .st_exl     (st_exl),
  .st_bev     (st_bev),
  .ebase      (ebase),
  .boot_base  (boot_base),
  .refill_hit (refill_hit),
  .rsp_valid  (rsp_valid),
  .next_pc    (next_pc),
  .code_we    (code_we),
  .epc_we     (epc_we),
  .bd_we      (bd_we),
  .exl_set    (exl_set),
  .errpc_we   (errpc_we),
  .erl_set    (erl_set),
  .bev_set    (bev_set),
  .depc_we    (depc_we),
  .dbg_flags  (dbg_flags)
);

// File: tb/sim_exc_vector_unit.sv
module sim_exc_vector_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  typedef struct packed {
    logic [4:0]  kind;
    logic [31:0] pc;
    logic        ds;
    logic        nm;
    logic        exl;
    logic        bev;
    logic [7:0]  im;
    logic        iv;
    logic [7:0]  ip;
    logic [4:0]  spc;
    logic        eic;
    logic [31:0] eb;
    logic [31:0] x_pc;
    logic [4:0]  x_code;
    logic        x_epcwe;
    logic [31:0] x_epc;
  } row_t;

  localparam int NROW = 16;
  localparam row_t TBL [NROW] = '{
    '{5'd8,  32'h0040_0100, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'h8000_1180, 5'd8,  1'b1, 32'h0040_0100},
    '{5'd2,  32'h0040_0200, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'h8000_1000, 5'd2,  1'b1, 32'h0040_0200},
    '{5'd3,  32'h0040_0300, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'h8000_1180, 5'd3,  1'b0, 32'h0},
    '{5'd2,  32'h0040_0400, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'h8000_1180, 5'd2,  1'b1, 32'h0040_0400},
    '{5'd3,  32'h0040_0500, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'hBFC0_0200, 5'd3,  1'b1, 32'h0040_0500},
    '{5'd0,  32'h0040_0600, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h24, 5'd1, 1'b0, 32'h8000_1234, 32'h8000_1180, 5'd0,  1'b1, 32'h0040_0600},
    '{5'd0,  32'h0040_0700, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 8'h24, 5'd0, 1'b0, 32'h8000_1234, 32'h8000_1200, 5'd0,  1'b1, 32'h0040_0700},
    '{5'd0,  32'h0040_0800, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 8'h24, 5'd4, 1'b0, 32'h8000_1234, 32'hBFC0_0400, 5'd0,  1'b1, 32'h0040_0800},
    '{5'd0,  32'h0040_0900, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 8'h24, 5'd1, 1'b0, 32'h8000_1234, 32'h8000_12A0, 5'd0,  1'b1, 32'h0040_0900},
    '{5'd0,  32'h0040_0A00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b1, 8'h24, 5'd1, 1'b0, 32'h8000_1234, 32'h8000_1240, 5'd0,  1'b1, 32'h0040_0A00},
    '{5'd0,  32'h0040_0B00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h07, 5'd2, 1'b1, 32'h8000_1234, 32'h8000_13C0, 5'd0,  1'b1, 32'h0040_0B00},
    '{5'd0,  32'h0040_0C00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 8'h00, 5'd3, 1'b0, 32'h8000_1234, 32'h8000_1200, 5'd0,  1'b1, 32'h0040_0C00},
    '{5'd30, 32'h0040_0D00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'hA000_1100, 5'd30, 1'b1, 32'h0040_0D00},
    '{5'd30, 32'h0040_0E00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'hBFC0_0300, 5'd30, 1'b1, 32'h0040_0E00},
    '{5'd30, 32'h0040_0F00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'hFFFF_F000, 32'hBFFF_F100, 5'd30, 1'b1, 32'h0040_0F00},
    '{5'd19, 32'h0040_0104, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 5'd0, 1'b0, 32'h8000_1234, 32'h8000_1180, 5'd19, 1'b1, 32'h0040_0100}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_kind = '0;
  logic [31:0] cur_pc = '0;
  logic        in_delay = 1'b0;
  logic        tlb_nomatch = 1'b0;
  logic        st_exl = 1'b0;
  logic        st_bev = 1'b0;
  logic [7:0]  st_im = '0;
  logic        ca_iv = 1'b0;
  logic [7:0]  ca_ip = '0;
  logic [4:0]  vec_spacing = '0;
  logic [31:0] ebase = '0;
  logic        eic_mode = 1'b0;
  logic [31:0] boot_base = BOOT;

  logic        rsp_valid, code_we, epc_we, bd_we, bd_val, exl_set, erl_set, bev_set;
  logic        errpc_we, depc_we;
  logic [31:0] next_pc, epc_val, errpc_val, depc_val;
  logic [4:0]  exc_code;
  logic [5:0]  dbg_flags;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .cur_pc(cur_pc), .in_delay(in_delay), .tlb_nomatch(tlb_nomatch),
    .st_exl(st_exl), .st_bev(st_bev), .st_im(st_im), .ca_iv(ca_iv),
    .ca_ip(ca_ip), .vec_spacing(vec_spacing), .ebase(ebase),
    .eic_mode(eic_mode), .boot_base(boot_base), .rsp_valid(rsp_valid),
    .next_pc(next_pc), .code_we(code_we), .exc_code(exc_code),
    .epc_we(epc_we), .epc_val(epc_val), .bd_we(bd_we), .bd_val(bd_val),
    .exl_set(exl_set), .erl_set(erl_set), .bev_set(bev_set),
    .errpc_we(errpc_we), .errpc_val(errpc_val), .depc_we(depc_we),
    .depc_val(depc_val), .dbg_flags(dbg_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input row_t r);
    @(negedge clk);
    req_kind = r.kind; cur_pc = r.pc; in_delay = r.ds; tlb_nomatch = r.nm;
    st_exl = r.exl; st_bev = r.bev; st_im = r.im; ca_iv = r.iv; ca_ip = r.ip;
    vec_spacing = r.spc; eic_mode = r.eic; ebase = r.eb;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic row_t mk(input logic [4:0] k, input logic [31:0] pc, input logic ds);
    row_t r;
    r = '0;
    r.kind = k; r.pc = pc; r.ds = ds; r.im = 8'hFF; r.eb = 32'h8000_1234;
    return r;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset next_pc", next_pc, 32'd0);
    chk("R1 reset write enables", 32'({code_we, epc_we, errpc_we, depc_we, dbg_flags}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle no response", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < NROW; i++) begin
      fire(TBL[i]);
      // R3 R4 R5 R6 R8: handler address
      chk($sformatf("R3/R4/R5/R6/R8 row %0d next_pc", i), next_pc, TBL[i].x_pc);
      chk($sformatf("R2 row %0d code", i), 32'(exc_code), 32'(TBL[i].x_code));
      chk($sformatf("R2 row %0d code_we", i), 32'({code_we, exl_set}), 32'd3);
      chk($sformatf("R7 row %0d epc_we", i), 32'({epc_we, bd_we}), {30'd0, {2{TBL[i].x_epcwe}}});
      if (TBL[i].x_epcwe) begin
        chk($sformatf("R7 row %0d epc", i), epc_val, TBL[i].x_epc);
        chk($sformatf("R7 row %0d bd", i), 32'(bd_val), 32'(TBL[i].ds));
      end
      chk($sformatf("R1 row %0d valid", i), 32'(rsp_valid), 32'd1);
      @(negedge clk);
      chk($sformatf("R1 row %0d single pulse", i), 32'(rsp_valid), 32'd0);
    end

    // R9: software breakpoint in delay slot
    fire(mk(5'd28, 32'h0040_2004, 1'b1));
    chk("R9 bp next_pc", next_pc, 32'hBFC0_0480);
    chk("R9 bp flags", 32'(dbg_flags), 32'h08);
    chk("R9 bp depc", depc_val, 32'h0040_2000);
    chk("R9 bp no general writes", 32'({depc_we, code_we, epc_we, exl_set}), 32'h8);

    // R9: single step keeps PC unchanged
    fire(mk(5'd25, 32'h0040_3004, 1'b1));
    chk("R9 step flags", 32'(dbg_flags), 32'h01);
    chk("R9 step depc", depc_val, 32'h0040_3004);

    // R9: data load break uses top flag bit
    fire(mk(5'd31, 32'h0040_3100, 1'b0));
    chk("R9 dload flags", 32'(dbg_flags), 32'h20);

    // R10: NMI
    fire(mk(5'd16, 32'h0040_4008, 1'b1));
    chk("R10 nmi next_pc", next_pc, BOOT);
    chk("R10 nmi levels", 32'({erl_set, bev_set, errpc_we, code_we, epc_we}), 32'h1C);
    chk("R10 nmi errpc", errpc_val, 32'h0040_4004);

    // R10: soft reset
    fire(mk(5'd17, 32'h0040_5000, 1'b0));
    chk("R10 srst errpc", errpc_val, 32'h0040_5000);
    chk("R10 srst next_pc", next_pc, BOOT);

    // R2: unlisted general code passes through (15)
    fire(mk(5'd15, 32'h0040_6000, 1'b0));
    chk("R2 code 15", 32'(exc_code), 32'd15);
    chk("R3 common offset", next_pc, 32'h8000_1180);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule